// File: doc/BRIEF.md
# Double-Buffered Cursor Register Bank with Armed Commit

This block keeps the configuration of a hardware cursor: a control word, a surface base address, a screen position and a partial-height control. Software writes over a simple write port. Every write goes into a pending copy. The cursor scanout engine only ever sees the active copy. The pending copy moves into the active copy, all four registers in the same cycle, at a vertical-blank pulse. That happens only if the pending set has been armed. This keeps the scanout engine from seeing a half-written shape or a base address that does not match its size.

A write to the base register arms the pending set. When the cursor is being switched on from the off state, the control write arms it. Any other cursor write made while an update is armed withdraws the arming, so the update does not commit until it is armed again. A build parameter selects how a position-only move behaves. In one variant, a position write arms itself as long as no control write has been made since the last commit. In the other variant, a position write always needs a following base write.

The active values are driven out decoded for the scanout engine: enable, width, height, signed X/Y, rotation, gamma, colour conversion, pipe select and base. They can also be read back as raw words by register offset.

Top module: `cursor_regs_dbuf`

## Requirements
- R1: After synchronous reset, all four active registers read back as zero, the cursor is disabled (width and height 0) and no update is armed.
- R2: A write to offset 0x4 (base) arms the pending set. At the next cycle with `vblank` high, the pending control, base, position and partial-height values all become active in the same cycle. Readback selects by `rd_addr[3:2]`: 0 control, 1 base, 2 position, 3 partial-height.
- R3: Writes never change the active values by themselves. A `vblank` pulse while nothing is armed has no effect. A commit clears the armed state.
- R4: A write to offset 0x0 (control) arms the pending set when the active mode field (bits 1:0) is zero and the written mode field is non-zero.
- R5: While armed, a write to offset 0xC, a control write that is not an enabling write, or a position write that does not arm itself (R6) cancels the armed state. A later `vblank` then leaves the active values unchanged until the set is armed again.
- R6: With `POS_SELF_ARM`=1, a write to offset 0x8 (position) arms the set if no control write has been made since the last commit (or reset). Otherwise it cancels the armed state. With `POS_SELF_ARM`=0, a position write never arms.
- R7: Position layout: X magnitude in bits 14:0 with its sign flag in bit 15, and Y magnitude in bits 30:16 with its sign flag in bit 31. `cur_x`/`cur_y` equal minus the magnitude when the flag is set and the magnitude otherwise.
- R8: Control bits 1:0 give the mode: 0 disabled (`cur_enable` low, width 0), 1 gives 64, 2 gives 128 and 3 gives 256 pixels wide.
- R9: Control bit 8 drives `cur_rot180`, bit 9 drives `cur_gamma`, bit 10 drives `cur_csc`, and bits 13:12 drive `cur_pipe`.
- R10: Partial-height: bit 31 enables it and bits 7:0 hold height minus one. When it is enabled, the height is that field plus one. Otherwise the cursor is square (height equals width). The height is 0 while the cursor is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte offset of the written register |
| wr_data | input | 32 | Write data |
| vblank | input | 1 | One-cycle vertical-blank pulse |
| rd_addr | input | 4 | Byte offset for active-value readback |
| rd_data | output | 32 | Active register selected by `rd_addr` |
| armed | output | 1 | Pending set will commit at the next vblank |
| cur_enable | output | 1 | Active cursor is on |
| cur_width | output | 9 | Active width in pixels |
| cur_height | output | 9 | Active height in lines |
| cur_x | output | 16 | Signed active X position |
| cur_y | output | 16 | Signed active Y position |
| cur_rot180 | output | 1 | 180-degree rotation |
| cur_gamma | output | 1 | Gamma enable |
| cur_csc | output | 1 | Colour-space conversion enable |
| cur_pipe | output | PIPE_W | Pipe select |
| cur_base | output | 32 | Active surface base |

## Verification
The bench builds two copies of the block side by side and drives them with the same stimulus: one with `POS_SELF_ARM`=1 and one with `POS_SELF_ARM`=0. The same write sequence then exposes both position-arming rules at once. Only the self-arming copy commits a bare position move, and both copies refuse it after a control write. Random writes, cancels and vblank pulses are compared against a reference model for each variant. Directed sequences cover the enable trigger, cancellation, negative coordinates and partial height.

// File: rtl/cursor_regs_dbuf.sv
module cursor_regs_dbuf #(
  parameter bit POS_SELF_ARM = 1'b1,
  parameter int PIPE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              vblank,
  input  logic [3:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic              armed,
  output logic              cur_enable,
  output logic [8:0]        cur_width,
  output logic [8:0]        cur_height,
  output logic signed [15:0] cur_x,
  output logic signed [15:0] cur_y,
  output logic              cur_rot180,
  output logic              cur_gamma,
  output logic              cur_csc,
  output logic [PIPE_W-1:0] cur_pipe,
  output logic [31:0]       cur_base
);
  localparam int PIPE_LSB = 12;

  logic [31:0] p_ctl, p_base, p_pos, p_ht;
  logic [31:0] a_ctl, a_base, a_pos, a_ht;
  logic        armed_q, ctl_seen;
  logic [1:0]  sel, mode;

  assign sel  = wr_addr[3:2];
  assign mode = a_ctl[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      p_ctl <= '0; p_base <= '0; p_pos <= '0; p_ht <= '0;
      a_ctl <= '0; a_base <= '0; a_pos <= '0; a_ht <= '0;
      armed_q  <= 1'b0;
      ctl_seen <= 1'b0;
    end else begin
      if (vblank && armed_q) begin
        a_ctl  <= p_ctl;
        a_base <= p_base;
        a_pos  <= p_pos;
        a_ht   <= p_ht;
        armed_q  <= 1'b0;
        ctl_seen <= 1'b0;
      end
      if (wr_en) begin
        case (sel)
          2'd0: begin
            p_ctl    <= wr_data;
            ctl_seen <= 1'b1;
            armed_q  <= (mode == 2'd0) && (wr_data[1:0] != 2'd0);
          end
          2'd1: begin
            p_base  <= wr_data;
            armed_q <= 1'b1;
          end
          2'd2: begin
            p_pos   <= wr_data;
            armed_q <= POS_SELF_ARM && !ctl_seen;
          end
          default: begin
            p_ht    <= wr_data;
            armed_q <= 1'b0;
          end
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr[3:2])
      2'd0:    rd_data = a_ctl;
      2'd1:    rd_data = a_base;
      2'd2:    rd_data = a_pos;
      default: rd_data = a_ht;
    endcase
  end

  assign armed      = armed_q;
  assign cur_enable = (mode != 2'd0);
  assign cur_width  = (mode == 2'd1) ? 9'd64 :
                      (mode == 2'd2) ? 9'd128 :
                      (mode == 2'd3) ? 9'd256 : 9'd0;
  assign cur_height = !cur_enable ? 9'd0 :
                      a_ht[31]    ? ({1'b0, a_ht[7:0]} + 9'd1) : cur_width;
  assign cur_x = a_pos[15] ? -$signed({1'b0, a_pos[14:0]}) : $signed({1'b0, a_pos[14:0]});
  assign cur_y = a_pos[31] ? -$signed({1'b0, a_pos[30:16]}) : $signed({1'b0, a_pos[30:16]});
  assign cur_rot180 = a_ctl[8];
  assign cur_gamma  = a_ctl[9];
  assign cur_csc    = a_ctl[10];
  assign cur_pipe   = a_ctl[PIPE_LSB +: PIPE_W];
  assign cur_base   = a_base;
endmodule

// File: rtl/cursor_regs_dbuf_chk.sv
module cursor_regs_dbuf_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [3:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        vblank,
  input logic        armed,
  input logic        cur_enable,
  input logic [8:0]  cur_width,
  input logic [31:0] cur_base
);
  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (!armed && !cur_enable && cur_base == 32'd0)); // R1
  AST_BASE_ARMS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[3:2] == 2'd1) |=> armed); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(vblank && armed) |=> $stable(cur_base)); // R3
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (vblank && armed && !wr_en) |=> !armed); // R3
  AST_ENABLE_ARMS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[3:2] == 2'd0 && wr_data[1:0] != 2'd0 && !cur_enable) |=> armed); // R4
  AST_HT_CANCELS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[3:2] == 2'd3) |=> !armed); // R5
  AST_OFF_NO_WIDTH: assert property (@(posedge clk) disable iff (rst)
    !cur_enable |-> (cur_width == 9'd0)); // R8
endmodule

bind cursor_regs_dbuf cursor_regs_dbuf_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .vblank(vblank), .armed(armed), .cur_enable(cur_enable),
  .cur_width(cur_width), .cur_base(cur_base)
);

// File: tb/cursor_regs_dbuf_tb_top.sv
module cursor_regs_dbuf_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic vblank = 1'b0;
  logic [3:0] rd_addr = '0;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  logic [31:0] rd [2];
  logic arm [2], en [2], rot [2], gam [2], csc [2];
  logic [8:0] wid [2], hgt [2];
  logic signed [15:0] xx [2], yy [2];
  logic [1:0] pip [2];
  logic [31:0] bas [2];

  cursor_regs_dbuf #(.POS_SELF_ARM(1'b1), .PIPE_W(2)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vblank(vblank), .rd_addr(rd_addr), .rd_data(rd[0]), .armed(arm[0]),
    .cur_enable(en[0]), .cur_width(wid[0]), .cur_height(hgt[0]), .cur_x(xx[0]),
    .cur_y(yy[0]), .cur_rot180(rot[0]), .cur_gamma(gam[0]), .cur_csc(csc[0]),
    .cur_pipe(pip[0]), .cur_base(bas[0]));

  cursor_regs_dbuf #(.POS_SELF_ARM(1'b0), .PIPE_W(2)) dut_b (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vblank(vblank), .rd_addr(rd_addr), .rd_data(rd[1]), .armed(arm[1]),
    .cur_enable(en[1]), .cur_width(wid[1]), .cur_height(hgt[1]), .cur_x(xx[1]),
    .cur_y(yy[1]), .cur_rot180(rot[1]), .cur_gamma(gam[1]), .cur_csc(csc[1]),
    .cur_pipe(pip[1]), .cur_base(bas[1]));

  logic [31:0] mp [2][4];
  logic [31:0] ma [2][4];
  bit m_arm [2], m_seen [2];

  function automatic logic [8:0] f_width(input logic [31:0] c);
    case (c[1:0])
      2'd1: return 9'd64;
      2'd2: return 9'd128;
      2'd3: return 9'd256;
      default: return 9'd0;
    endcase
  endfunction

  function automatic logic [8:0] f_height(input logic [31:0] c, input logic [31:0] h);
    if (c[1:0] == 2'd0) return 9'd0;
    if (h[31]) return 9'(h[7:0]) + 9'd1;
    return f_width(c);
  endfunction

  function automatic logic signed [15:0] f_coord(input logic s, input logic [14:0] m);
    return s ? -16'(m) : 16'(m);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int v = 0; v < 2; v++) begin
      chk(req, "armed", 32'(arm[v]), 32'(m_arm[v]));
      chk("R8", "enable", 32'(en[v]), 32'(ma[v][0][1:0] != 2'd0));
      chk("R8", "width", 32'(wid[v]), 32'(f_width(ma[v][0])));
      chk("R10", "height", 32'(hgt[v]), 32'(f_height(ma[v][0], ma[v][3])));
      chk("R7", "x", 32'(xx[v]), 32'(f_coord(ma[v][2][15], ma[v][2][14:0])));
      chk("R7", "y", 32'(yy[v]), 32'(f_coord(ma[v][2][31], ma[v][2][30:16])));
      chk("R9", "flags", {29'd0, rot[v], gam[v], csc[v]},
          {29'd0, ma[v][0][8], ma[v][0][9], ma[v][0][10]});
      chk("R9", "pipe", 32'(pip[v]), 32'(ma[v][0][13:12]));
      chk(req, "base", bas[v], ma[v][1]);
    end
    for (int r = 0; r < 4; r++) begin
      rd_addr = 4'(r * 4);
      #1;
      for (int v = 0; v < 2; v++) chk(req, "readback", rd[v], ma[v][r]);
    end
  endtask

  task automatic do_wr(input int r, input logic [31:0] d, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(r * 4); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    for (int v = 0; v < 2; v++) begin
      mp[v][r] = d;
      case (r)
        0: begin m_arm[v] = (ma[v][0][1:0] == 2'd0) && (d[1:0] != 2'd0); m_seen[v] = 1; end
        1: m_arm[v] = 1;
        2: m_arm[v] = (v == 0) && !m_seen[v];
        default: m_arm[v] = 0;
      endcase
    end
    check_all(req);
  endtask

  task automatic do_vb(input string req);
    @(negedge clk);
    vblank = 1'b1;
    @(negedge clk);
    vblank = 1'b0;
    for (int v = 0; v < 2; v++)
      if (m_arm[v]) begin
        for (int r = 0; r < 4; r++) ma[v][r] = mp[v][r];
        m_arm[v] = 0; m_seen[v] = 0;
      end
    check_all(req);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int v = 0; v < 2; v++) begin
      for (int r = 0; r < 4; r++) begin mp[v][r] = '0; ma[v][r] = '0; end
      m_arm[v] = 0; m_seen[v] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1");

    // R4: enable trigger via control write; R8/R9 fields
    do_wr(0, 32'h0000_2702, "R4");
    do_wr(3, 32'h8000_001F, "R5");
    do_vb("R5");
    do_wr(1, 32'h0001_0000, "R2");
    do_vb("R2");
    // R7: negative coordinates, R6: bare position move
    do_wr(2, 32'h8005_800A, "R6");
    do_vb("R6");
    // R6: control write then position cancels, base re-arms
    do_wr(0, 32'h0000_0303, "R6");
    do_wr(2, 32'h0010_0020, "R6");
    do_vb("R6");
    do_wr(1, 32'h0002_0000, "R2");
    do_vb("R2");
    do_vb("R3");
    // R10: partial height then square
    do_wr(3, 32'h8000_0007, "R10");
    do_wr(1, 32'h0003_0000, "R10");
    do_vb("R10");
    do_wr(3, 32'h0000_0000, "R10");
    do_wr(1, 32'h0003_0000, "R10");
    do_vb("R10");
    // R8: disable
    do_wr(0, 32'h0000_0000, "R8");
    do_wr(1, 32'h0004_0000, "R8");
    do_vb("R8");

    for (int i = 0; i < 1500; i++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom_range(0, 5));
      d = $urandom();
      if (op == 5) do_vb("R3");
      else if (op == 4) begin @(negedge clk); check_all("R3"); end
      else do_wr(op, d, "R5");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule